// File: doc/BRIEF.md
# Scatter-Gather Descriptor Table Walker

This block is a bus-master DMA engine. It moves a buffer of a requested byte length between a local data buffer and a set of host memory regions. A table of 8-byte descriptors in host memory names those regions, and the engine walks that table. Each descriptor is fetched as two 32-bit reads through a simple request/grant memory port. The engine decodes each descriptor into a region address, a byte count and an end-of-table flag. It then moves the data in beats of at most four bytes, region after region, until the requested length has been moved.

The transfer ends in one of two ways. If the requested length is satisfied, the engine ends with a clean completion. If the table runs out first, it ends with a short-table indication. The table runs out when the end flag has been consumed, or when a full 4 KiB page of descriptors has been read without any end flag.

A host-side controller loads the table base, the length and the direction, then pulses start. It waits for the one-cycle done pulse and reads the short flag that comes with it.

Top module: `sg_walker`

## Requirements
- R1: Descriptor n sits at table base + 8n. It is read as two 4-byte little-endian reads: the region address from the fetch pointer, then the size word from pointer + 4. The pointer then advances by 8.
- R2: The region byte count is the size word ANDed with 0xFFFE, so bit 0 of the size word never adds a byte.
- R3: A masked count of zero describes a region of 65536 bytes.
- R4: Bit 31 of the size word flags the final descriptor. Once its region is used up, no further descriptor is read.
- R5: No descriptor is read once the fetch pointer is 4096 or more bytes past the table base (at most 512 descriptors per transfer). Running out this way while bytes are still owed ends the transfer as short.
- R6: A descriptor is read only when the current region has no bytes left and bytes are still owed. A transfer that is already satisfied reads no more descriptors.
- R7: Each data beat carries the smaller of three amounts: the bytes still owed, the bytes left in the region, and 4. The region address and the buffer index both advance by the beat size. Byte lane j of a beat maps to address + j and to buffer index + j.
- R8: With to_host_i = 1, buffer bytes are written to host memory. With to_host_i = 0, host bytes are read into the buffer.
- R9: done_o pulses for exactly one cycle per transfer. short_o is 1 with it when the table ran out before the length was met, and 0 otherwise. A zero-length request completes at once with no memory access.
- R10: Start latches the base, the length and the direction. It reloads the fetch pointer from the base and clears the region address, length and end flag. A start while busy_o is high is ignored.
- R11: A memory request holds its address and controls steady until it is granted. Only one request is outstanding at a time, and read data arrives on mem_rvalid_i after the grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, sampled while idle |
| to_host_i | input | 1 | 1: buffer to host, 0: host to buffer |
| table_base_i | input | AW | Host address of the descriptor table |
| xfer_len_i | input | LEN_W | Requested byte count |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| short_o | output | 1 | Valid with done_o: table ended early |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | AW | Byte address of request |
| mem_nbytes_o | output | NB_W | Bytes in request (1 to BEAT_BYTES) |
| mem_wdata_o | output | DW | Write data, lane j at address + j |
| mem_gnt_i | input | 1 | Request accepted |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | DW | Read data |
| buf_raddr_o | output | LEN_W | Local buffer read index |
| buf_rdata_i | input | DW | Local buffer read data (combinational) |
| buf_we_o | output | 1 | Local buffer write strobe |
| buf_waddr_o | output | LEN_W | Local buffer write index |
| buf_wdata_o | output | DW | Local buffer write data |
| buf_wbytes_o | output | NB_W | Bytes valid in buffer write |

## Verification
A host read costs one cycle in the request state until the grant edge, and the data is taken on the edge where mem_rvalid_i is high. The buffer write port is registered on that same edge and stays valid for one cycle. done_o follows one cycle after the decision step and comes two edges after the final accepting edge. The bench drives and samples only on falling edges, so it sees each registered result in the half-cycle after it settles. Its memory model checks a pending request at the next falling edge against the one it saw before. The bench waits for the done pulse with a timeout, not a fixed delay, and compares the data, the descriptor read count and the short flag only after the pulse.

// File: rtl/sgw_pkg.sv
package sgw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_EVAL, ST_FA, ST_WA, ST_FS, ST_WS, ST_DREQ, ST_DWAIT
  } sgw_state_e;
  localparam int unsigned DESC_BYTES = 8;
  localparam int unsigned CNT_W      = 17;
endpackage

// File: rtl/sgw_desc_decode.sv
module sgw_desc_decode
  import sgw_pkg::*;
(
  input  logic [31:0]      size_word_i,
  output logic [CNT_W-1:0] region_len_o,
  output logic             last_o
);
  logic [15:0] masked;
  assign masked       = size_word_i[15:0] & 16'hFFFE;
  assign region_len_o = (masked == 16'h0) ? CNT_W'(17'h10000) : CNT_W'(masked);
  assign last_o       = size_word_i[31];

  logic unused_mid;
  assign unused_mid = ^size_word_i[30:16];
endmodule

// File: rtl/sgw_beat_size.sv
module sgw_beat_size
  import sgw_pkg::*;
#(
  parameter int unsigned LEN_W      = 16,
  parameter int unsigned BEAT_BYTES = 4,
  localparam int unsigned NB_W      = $clog2(BEAT_BYTES + 1)
) (
  input  logic [LEN_W-1:0] owed_i,
  input  logic [CNT_W-1:0] reg_len_i,
  output logic [NB_W-1:0]  nb_o
);
  logic [31:0] o32, r32, m;
  always_comb begin
    o32  = 32'(owed_i);
    r32  = 32'(reg_len_i);
    m    = (o32 < r32) ? o32 : r32;
    nb_o = (m >= 32'(BEAT_BYTES)) ? NB_W'(BEAT_BYTES) : NB_W'(m);
  end
endmodule

// File: rtl/sg_walker.sv
module sg_walker
  import sgw_pkg::*;
#(
  parameter int unsigned LEN_W      = 16,
  parameter int unsigned AW         = 32,
  parameter int unsigned PAGE_BYTES = 4096,
  parameter int unsigned BEAT_BYTES = 4,
  localparam int unsigned DW        = 8 * BEAT_BYTES,
  localparam int unsigned NB_W      = $clog2(BEAT_BYTES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             to_host_i,
  input  logic [AW-1:0]    table_base_i,
  input  logic [LEN_W-1:0] xfer_len_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             short_o,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic [NB_W-1:0]  mem_nbytes_o,
  output logic [DW-1:0]    mem_wdata_o,
  input  logic             mem_gnt_i,
  input  logic             mem_rvalid_i,
  input  logic [DW-1:0]    mem_rdata_i,
  output logic [LEN_W-1:0] buf_raddr_o,
  input  logic [DW-1:0]    buf_rdata_i,
  output logic             buf_we_o,
  output logic [LEN_W-1:0] buf_waddr_o,
  output logic [DW-1:0]    buf_wdata_o,
  output logic [NB_W-1:0]  buf_wbytes_o
);
  sgw_state_e       state_q;
  logic [AW-1:0]    ptr_q, base_q, raddr_q;
  logic [CNT_W-1:0] rlen_q;
  logic             last_q, to_host_q, done_q, short_q;
  logic [LEN_W-1:0] owed_q, idx_q;
  logic             bwe_q;
  logic [LEN_W-1:0] bwaddr_q;
  logic [DW-1:0]    bwdata_q;
  logic [NB_W-1:0]  bwbytes_q;

  logic [CNT_W-1:0] dec_len;
  logic             dec_last;
  logic [NB_W-1:0]  nb;
  logic [AW-1:0]    offset;
  logic             guard_hit;

  sgw_desc_decode u_dec (
    .size_word_i (mem_rdata_i[31:0]),
    .region_len_o(dec_len),
    .last_o      (dec_last)
  );

  sgw_beat_size #(.LEN_W(LEN_W), .BEAT_BYTES(BEAT_BYTES)) u_beat (
    .owed_i   (owed_q),
    .reg_len_i(rlen_q),
    .nb_o     (nb)
  );

  assign offset    = ptr_q - base_q;
  assign guard_hit = offset >= AW'(PAGE_BYTES);

  always_comb begin
    mem_req_o    = (state_q == ST_FA) || (state_q == ST_FS) || (state_q == ST_DREQ);
    mem_we_o     = (state_q == ST_DREQ) && to_host_q;
    mem_addr_o   = raddr_q;
    mem_nbytes_o = nb;
    if (state_q == ST_FA) begin
      mem_addr_o   = ptr_q;
      mem_nbytes_o = NB_W'(4);
    end else if (state_q == ST_FS) begin
      mem_addr_o   = ptr_q + AW'(4);
      mem_nbytes_o = NB_W'(4);
    end
  end

  assign mem_wdata_o  = buf_rdata_i;
  assign buf_raddr_o  = idx_q;
  assign busy_o       = state_q != ST_IDLE;
  assign done_o       = done_q;
  assign short_o      = short_q;
  assign buf_we_o     = bwe_q;
  assign buf_waddr_o  = bwaddr_q;
  assign buf_wdata_o  = bwdata_q;
  assign buf_wbytes_o = bwbytes_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      ptr_q     <= '0;
      base_q    <= '0;
      raddr_q   <= '0;
      rlen_q    <= '0;
      last_q    <= 1'b0;
      to_host_q <= 1'b0;
      owed_q    <= '0;
      idx_q     <= '0;
      done_q    <= 1'b0;
      short_q   <= 1'b0;
      bwe_q     <= 1'b0;
      bwaddr_q  <= '0;
      bwdata_q  <= '0;
      bwbytes_q <= '0;
    end else begin
      done_q <= 1'b0;
      bwe_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          base_q    <= table_base_i;
          ptr_q     <= table_base_i;
          raddr_q   <= '0;
          rlen_q    <= '0;
          last_q    <= 1'b0;
          owed_q    <= xfer_len_i;
          idx_q     <= '0;
          to_host_q <= to_host_i;
          short_q   <= 1'b0;
          state_q   <= ST_EVAL;
        end
        ST_EVAL: begin
          if (owed_q == '0) begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else if (rlen_q == '0) begin
            if (last_q || guard_hit) begin
              done_q  <= 1'b1;
              short_q <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              state_q <= ST_FA;
            end
          end else begin
            state_q <= ST_DREQ;
          end
        end
        ST_FA: if (mem_gnt_i) state_q <= ST_WA;
        ST_WA: if (mem_rvalid_i) begin
          raddr_q <= mem_rdata_i[31:0];
          state_q <= ST_FS;
        end
        ST_FS: if (mem_gnt_i) state_q <= ST_WS;
        ST_WS: if (mem_rvalid_i) begin
          rlen_q  <= dec_len;
          last_q  <= dec_last;
          ptr_q   <= ptr_q + AW'(DESC_BYTES);
          state_q <= ST_EVAL;
        end
        ST_DREQ: if (mem_gnt_i) begin
          if (to_host_q) begin
            raddr_q <= raddr_q + AW'(nb);
            rlen_q  <= rlen_q - CNT_W'(nb);
            owed_q  <= owed_q - LEN_W'(nb);
            idx_q   <= idx_q + LEN_W'(nb);
            state_q <= ST_EVAL;
          end else begin
            state_q <= ST_DWAIT;
          end
        end
        ST_DWAIT: if (mem_rvalid_i) begin
          bwe_q     <= 1'b1;
          bwaddr_q  <= idx_q;
          bwdata_q  <= mem_rdata_i;
          bwbytes_q <= nb;
          raddr_q   <= raddr_q + AW'(nb);
          rlen_q    <= rlen_q - CNT_W'(nb);
          owed_q    <= owed_q - LEN_W'(nb);
          idx_q     <= idx_q + LEN_W'(nb);
          state_q   <= ST_EVAL;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R11: request held steady until granted
  p_req_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_gnt_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));
  // R6: descriptor read only with an empty region
  p_fetch_empty_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FA) |-> (rlen_q == '0) && (owed_q != '0));
  // R2: decoded count is always even
  p_even_count_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WS) && mem_rvalid_i |=> rlen_q[0] == 1'b0);
  // R3: zero count loads a 64 KiB region
  p_zero_is_64k_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WS) && mem_rvalid_i && (mem_rdata_i[15:1] == 15'h0)
    |=> rlen_q == CNT_W'(17'h10000));
  // R5: fetch pointer never passes one page of descriptors
  p_window_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    offset <= AW'(PAGE_BYTES));
  // R9: done is a single-cycle pulse and its flag matches the cause
  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_short_cause_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && short_o |-> (last_q || guard_hit) && (rlen_q == '0) && (owed_q != '0));
  p_full_cause_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !short_o |-> owed_q == '0);
  // R7: data beats carry between 1 and BEAT_BYTES bytes
  p_beat_cap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DREQ) |-> (mem_nbytes_o != '0) && (mem_nbytes_o <= NB_W'(BEAT_BYTES)));
endmodule

// File: tb/sg_walker_tb_top.sv
module sg_walker_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        to_host = 1'b0;
  logic [31:0] tbl_base = '0;
  logic [15:0] xlen = '0;
  logic        busy, done, short_f;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [2:0]  mem_nbytes;
  logic        mem_gnt = 1'b0;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic [15:0] buf_raddr, buf_waddr;
  logic [31:0] buf_rdata, buf_wdata;
  logic        buf_we;
  logic [2:0]  buf_wbytes;

  always #4 clk = ~clk;

  sg_walker dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .to_host_i(to_host),
    .table_base_i(tbl_base), .xfer_len_i(xlen), .busy_o(busy), .done_o(done),
    .short_o(short_f), .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_nbytes_o(mem_nbytes), .mem_wdata_o(mem_wdata), .mem_gnt_i(mem_gnt),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata), .buf_raddr_o(buf_raddr),
    .buf_rdata_i(buf_rdata), .buf_we_o(buf_we), .buf_waddr_o(buf_waddr),
    .buf_wdata_o(buf_wdata), .buf_wbytes_o(buf_wbytes)
  );

  logic [7:0] host_mem [int];
  logic [7:0] loc_buf  [0:4095];
  int         exp_addr [0:4095];
  int checks = 0, fails = 0, cyc = 0;
  int exp_n, exp_fetch, moved, fetches, proto_err, beat_err, cur_tbl;
  bit exp_short, rd_pend, prev_wait, prev_we, finished;
  logic [31:0] paddr, prev_addr;
  logic [2:0]  pbytes;

  function automatic logic [7:0] hrd(input int a);
    if (host_mem.exists(a)) return host_mem[a];
    return 8'h00;
  endfunction

  function automatic logic [31:0] rd32(input int a);
    return {hrd(a + 3), hrd(a + 2), hrd(a + 1), hrd(a)};
  endfunction

  task automatic put_desc(input int at, input logic [31:0] ra, input logic [31:0] sz);
    for (int j = 0; j < 4; j++) begin
      host_mem[at + j]     = ra[8*j +: 8];
      host_mem[at + 4 + j] = sz[8*j +: 8];
    end
  endtask

  assign buf_rdata = {loc_buf[12'(buf_raddr + 16'd3)], loc_buf[12'(buf_raddr + 16'd2)],
                      loc_buf[12'(buf_raddr + 16'd1)], loc_buf[12'(buf_raddr)]};

  // host memory responder and buffer write port, all on falling edges
  always @(negedge clk) begin
    if (buf_we)
      for (int j = 0; j < int'(buf_wbytes); j++)
        loc_buf[12'(buf_waddr + 16'(j))] = buf_wdata[8*j +: 8];
    if (prev_wait && (!mem_req || mem_addr != prev_addr || mem_we != prev_we))
      proto_err++;
    if (mem_rvalid) mem_rvalid = 1'b0;
    if (rd_pend) begin
      for (int j = 0; j < 4; j++)
        mem_rdata[8*j +: 8] = (j < int'(pbytes)) ? hrd(int'(paddr) + j) : 8'h00;
      mem_rvalid = 1'b1;
      rd_pend    = 1'b0;
    end
    if (mem_gnt) mem_gnt = 1'b0;
    else if (mem_req && !mem_rvalid && ($urandom % 3 != 0)) begin
      mem_gnt = 1'b1;
      if (mem_nbytes == 3'd0 || mem_nbytes > 3'd4) beat_err++;
      if (mem_we) begin
        for (int j = 0; j < int'(mem_nbytes); j++)
          host_mem[int'(mem_addr) + j] = mem_wdata[8*j +: 8];
        moved += int'(mem_nbytes);
      end else begin
        rd_pend = 1'b1;
        paddr   = mem_addr;
        pbytes  = mem_nbytes;
        if (int'(mem_addr) >= cur_tbl && int'(mem_addr) < cur_tbl + 4104 &&
            ((int'(mem_addr) - cur_tbl) % 8 == 0))
          fetches++;
        else if (!((int'(mem_addr) - cur_tbl) % 8 == 4 &&
                   int'(mem_addr) > cur_tbl && int'(mem_addr) < cur_tbl + 4104))
          moved += int'(mem_nbytes);
      end
    end
    prev_wait = mem_req && !mem_gnt;
    prev_addr = mem_addr;
    prev_we   = mem_we;
  end

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 190000);
      summary();
    end
  end

  // expected walk computed from R1-style rules stated per requirement
  task automatic model(input int base, input int len);
    int ptr, owed, rl, ra, c;
    bit last;
    logic [31:0] sz;
    ptr = base; owed = len; rl = 0; ra = 0; last = 1'b0;
    exp_n = 0; exp_fetch = 0; exp_short = 1'b0;
    while (1) begin
      if (owed == 0) break;
      if (rl == 0) begin
        if (last || (ptr - base) >= 4096) begin exp_short = 1'b1; break; end
        ra = int'(rd32(ptr));
        sz = rd32(ptr + 4);
        ptr += 8; exp_fetch++;
        rl = int'(sz & 32'h0000_FFFE);
        if (rl == 0) rl = 65536;
        last = sz[31];
      end
      c = (owed < rl) ? owed : rl;
      for (int i = 0; i < c; i++) begin
        exp_addr[exp_n] = ra + i;
        exp_n++;
      end
      ra += c; rl -= c; owed -= c;
    end
  endtask

  task automatic run(input string tag, input int base, input int len, input bit dir,
                     input bit poke);
    int waited, errs;
    bit got_short, seen;
    model(base, len);
    for (int i = 0; i < 4096; i++) loc_buf[i] = 8'($urandom);
    if (!dir) for (int k = 0; k < exp_n; k++) host_mem[exp_addr[k]] = 8'($urandom);
    cur_tbl = base; moved = 0; fetches = 0;
    @(negedge clk);
    tbl_base = 32'(base); xlen = 16'(len); to_host = dir; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waited = 0; seen = 1'b0; got_short = 1'b0;
    while (!seen && waited < 20000) begin
      if (done) begin seen = 1'b1; got_short = short_f; end
      else begin
        @(negedge clk);
        waited++;
        // R10: a second start while busy must be ignored
        if (poke && waited == 6) begin
          tbl_base = 32'h2000; xlen = 16'd7; to_host = ~dir; start = 1'b1;
        end else start = 1'b0;
      end
    end
    start = 1'b0;
    check(tag, "done pulse seen (R9)", int'(seen), 1);
    check(tag, "short flag (R9)", int'(got_short), int'(exp_short));
    check(tag, "descriptor reads (R6)", fetches, exp_fetch);
    check(tag, "bytes moved (R7)", moved, exp_n);
    errs = 0;
    for (int k = 0; k < exp_n; k++)
      if (dir) begin if (hrd(exp_addr[k]) != loc_buf[k]) errs++; end
      else     begin if (loc_buf[k] != hrd(exp_addr[k])) errs++; end
    check(tag, "data bytes mismatched (R7 R8)", errs, 0);
    @(negedge clk);
    check(tag, "done lasts one cycle (R9)", int'(done), 0);
  endtask

  initial begin
    int n, total, da, cnt, xl;
    logic [31:0] sz;
    void'($urandom(32'd2024));
    #20;
    @(negedge clk);
    check("R9", "reset done", int'(done), 0);
    check("R10", "reset busy", int'(busy), 0);
    check("R11", "reset req", int'(mem_req), 0);
    rst_n = 1'b1;

    // R9: zero length, no memory access
    put_desc(32'h1000, 32'h8000, 32'h8000_0010);
    run("R9", 32'h1000, 0, 1'b0, 1'b0);

    // R2: size word 7 gives a 6-byte region
    put_desc(32'h1000, 32'h8000, 32'h8000_0007);
    run("R2", 32'h1000, 10, 1'b0, 1'b0);

    // R3: zero count is 64 KiB, so the second descriptor is never read
    put_desc(32'h1000, 32'h9000, 32'h0000_0000);
    put_desc(32'h1008, 32'h9800, 32'h8000_0010);
    run("R3", 32'h1000, 300, 1'b1, 1'b0);

    // R5: 513 descriptors, no end flag; only 512 may be read
    for (int i = 0; i < 513; i++) put_desc(32'h2000 + 8 * i, 32'hA000 + 4 * i, 32'h0000_0002);
    run("R5", 32'h2000, 4000, 1'b0, 1'b0);

    // R4: end flag stops the walk, next entry never read
    put_desc(32'h1000, 32'h8100, 32'h0000_0020);
    put_desc(32'h1008, 32'h8200, 32'h8000_0011);
    put_desc(32'h1010, 32'h8300, 32'h0000_0040);
    run("R4", 32'h1000, 100, 1'b1, 1'b0);

    // R10: start pulse during a busy run is ignored
    put_desc(32'h1000, 32'h8400, 32'h0000_0080);
    put_desc(32'h1008, 32'h8600, 32'h8000_0080);
    run("R10", 32'h1000, 200, 1'b0, 1'b1);

    // R1: random tables, lengths and directions
    for (int t = 0; t < 20; t++) begin
      n = 1 + int'($urandom % 6); total = 0; da = 32'h8000;
      for (int i = 0; i < n; i++) begin
        cnt = 2 + int'($urandom % 300);
        sz  = 32'(cnt) | ((i == n - 1) ? 32'h8000_0000 : 32'h0);
        put_desc(32'h1000 + 8 * i, 32'(da + int'($urandom % 5)), sz);
        total += cnt & 32'hFFFE;
        da += 32'h200;
      end
      xl = ($urandom % 3 == 0) ? total + 1 + int'($urandom % 50) : 1 + int'($urandom % total);
      run("R1", 32'h1000, xl, 1'($urandom), 1'b0);
    end

    check("R11", "request changed before grant", proto_err, 0);
    check("R7", "beat size out of range", beat_err, 0);
    summary();
  end
endmodule